// File: doc/BRIEF.md
# GPIO Port with Pullup Control

This block is a general-purpose I/O port of `WIDTH` pins (eight by default). Software reaches it through a small register bus with a write strobe, an address, write data and combinational read data. Two writable registers hold the port state. The first is a data latch. The second is a direction register, in which a 1 makes a pin an output. A third, read-only register returns the pin levels after they pass through a synchronizer.

Each pin's latch bit has one of two meanings, and the direction bit picks which. When the pin is an output, the pad is enabled and the latch bit is the level it drives. When the pin is an input, the pad is not driven and the latch bit switches the pin's weak pullup on (1) or off (0). The direction register is a separate store, so turning a pin around never disturbs its latch bit. A pin that returns to input mode gets back the pullup setting it had before. All three pad controls come straight from flops.

Top module: `gpio_port`

## Requirements
- R1: The latch register is at address 0. Each of its `WIDTH` bits can be written and read back independently, and a read returns the last value written.
- R2: When a pin's direction bit (address 1) is 1, its `pad_oe` bit is 1 and its `pad_do` bit equals its latch bit.
- R3: When a pin's direction bit is 0, its `pad_oe` and `pad_do` bits are 0 and its `pad_pu` bit equals its latch bit.
- R4: A write to the direction register leaves every latch bit unchanged.
- R5: After reset the latch reads all ones and the direction register reads all zeros. The pads show `pad_oe` = 0, `pad_do` = 0 and `pad_pu` = all ones.
- R6: A read of address 0 returns the latched value, not the level on the pins, in either direction mode.
- R7: Address 2 returns `pad_in` through a two-flop synchronizer. A change on `pad_in` that is set up before clock edge k is not visible at edge k and is visible after edge k+1.
- R8: A write is stored at the clock edge that samples `bus_wr`. The pad outputs follow one clock edge later.
- R9: Address 3 reads as zero, and a write to it changes neither register nor any pad output.
- R10: Direction is per pin. In a mixed setting, output pins drive their latch bits while input pins apply theirs as pullups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Register select: 0 latch, 1 direction, 2 pin levels |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for the register at `bus_addr` |
| pad_in | input | WIDTH | Pin levels from the pads, asynchronous |
| pad_oe | output | WIDTH | Per-pin output enable to the pads |
| pad_do | output | WIDTH | Per-pin output data to the pads |
| pad_pu | output | WIDTH | Per-pin weak pullup enable to the pads |

## Verification
The bench turns pins around with a known pattern in the latch. A design that cleared or rewrote the latch on a direction write would return wrong read-back data and show the wrong pullups once the pins became inputs again. It drives `pad_in` with the inverse of the latch, so a read mux that returned pin levels at address 0 is caught at once. It samples the pin register one edge and two edges after an input change, which catches a synchronizer that is too short or too long. It also samples the pads in the cycle right after a write, which catches pad outputs that are combinational instead of registered.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   // Register selected by the bus address
   typedef enum logic [1:0] {
      RS_LATCH = 2'd0,
      RS_DIR   = 2'd1,
      RS_PIN   = 2'd2,
      RS_NONE  = 2'd3
   } reg_sel_e;

   // Bus address of each register
   localparam int unsigned ADDR_LATCH = 0;
   localparam int unsigned ADDR_DIR   = 1;
   localparam int unsigned ADDR_PIN   = 2;

   // Lowest and highest accepted values of the structural parameters
   localparam int unsigned MIN_WIDTH  = 1;
   localparam int unsigned MAX_WIDTH  = 32;
   localparam int unsigned MIN_ADDR_W = 2;
   localparam int unsigned MAX_ADDR_W = 16;
   localparam int unsigned MIN_SYNC   = 2;
   localparam int unsigned MAX_SYNC   = 4;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH     = 8,
   parameter logic [WIDTH-1:0] LATCH_RST = '1,
   parameter logic [WIDTH-1:0] DIR_RST   = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  reg_sel_e         sel_i,
   input  logic [WIDTH-1:0] wdata_i,
   output logic [WIDTH-1:0] latch_o,
   output logic [WIDTH-1:0] dir_o
);

   logic             latch_we;
   logic             dir_we;
   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] dir_q;

   // Write decode. The pin register and unmapped addresses take no write.
   always_comb begin
      latch_we = 1'b0;
      dir_we   = 1'b0;
      if (wr_i) begin
         unique case (sel_i)
            RS_LATCH: latch_we = 1'b1;
            RS_DIR:   dir_we   = 1'b1;
            default: ;
         endcase
      end
   end

   // Data latch: its only write path is its own address
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        latch_q <= LATCH_RST;
      else if (latch_we) latch_q <= wdata_i;
   end

   // Direction store, kept apart from the latch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= DIR_RST;
      else if (dir_we) dir_q <= wdata_i;
   end

   assign latch_o = latch_q;
   assign dir_o   = dir_q;

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   localparam int unsigned LAST = STAGES - 1;

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[LAST-1:0], async_i[b]};
      end

      assign sync_o[b] = chain_q[LAST];
   end

endmodule

// File: rtl/gpio_port_pad.sv
module gpio_port_pad #(
   parameter int unsigned WIDTH     = 8,
   parameter logic [WIDTH-1:0] LATCH_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] latch_i,
   input  logic [WIDTH-1:0] dir_i,
   output logic [WIDTH-1:0] oe_o,
   output logic [WIDTH-1:0] do_o,
   output logic [WIDTH-1:0] pu_o
);

   // One pad slice per pin. The latch bit drives the pin or sets its pullup.
   for (genvar p = 0; p < WIDTH; p++) begin : g_pin
      logic oe_d, do_d, pu_d;
      logic oe_q, do_q, pu_q;

      always_comb begin
         oe_d = dir_i[p];
         do_d = dir_i[p] & latch_i[p];
         pu_d = ~dir_i[p] & latch_i[p];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            oe_q <= 1'b0;
            do_q <= 1'b0;
            pu_q <= LATCH_RST[p];
         end else begin
            oe_q <= oe_d;
            do_q <= do_d;
            pu_q <= pu_d;
         end
      end

      assign oe_o[p] = oe_q;
      assign do_o[p] = do_q;
      assign pu_o[p] = pu_q;
   end

endmodule

// File: rtl/gpio_port_rdmux.sv
module gpio_port_rdmux
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH     = 8,
   parameter bit          READ_FLOP = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  reg_sel_e         sel_i,
   input  logic [WIDTH-1:0] latch_i,
   input  logic [WIDTH-1:0] dir_i,
   input  logic [WIDTH-1:0] pin_i,
   output logic [WIDTH-1:0] rdata_o
);

   logic [WIDTH-1:0] rd_mux;

   always_comb begin
      unique case (sel_i)
         RS_LATCH: rd_mux = latch_i;
         RS_DIR:   rd_mux = dir_i;
         RS_PIN:   rd_mux = pin_i;
         default:  rd_mux = '0;
      endcase
   end

   if (READ_FLOP) begin : g_rd_flop
      logic [WIDTH-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_mux;
      end
      assign rdata_o = rd_q;
   end else begin : g_rd_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign rdata_o    = rd_mux;
   end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          READ_FLOP   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pad_in,
   output logic [WIDTH-1:0]  pad_oe,
   output logic [WIDTH-1:0]  pad_do,
   output logic [WIDTH-1:0]  pad_pu
);

   localparam logic [WIDTH-1:0] LATCH_RST = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] DIR_RST   = {WIDTH{1'b0}};

   // Elaboration-time parameter checks
   if (WIDTH < MIN_WIDTH || WIDTH > MAX_WIDTH) begin : g_bad_width
      $error("gpio_port: WIDTH out of range");
   end
   if (ADDR_W < MIN_ADDR_W || ADDR_W > MAX_ADDR_W) begin : g_bad_addr
      $error("gpio_port: ADDR_W out of range");
   end
   if (SYNC_STAGES < MIN_SYNC || SYNC_STAGES > MAX_SYNC) begin : g_bad_sync
      $error("gpio_port: SYNC_STAGES out of range");
   end

   reg_sel_e         sel;
   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] pin_sync;

   always_comb begin
      if (bus_addr == ADDR_W'(ADDR_LATCH))    sel = RS_LATCH;
      else if (bus_addr == ADDR_W'(ADDR_DIR)) sel = RS_DIR;
      else if (bus_addr == ADDR_W'(ADDR_PIN)) sel = RS_PIN;
      else                                    sel = RS_NONE;
   end

   gpio_port_regs #(
      .WIDTH     (WIDTH),
      .LATCH_RST (LATCH_RST),
      .DIR_RST   (DIR_RST)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (bus_wr),
      .sel_i   (sel),
      .wdata_i (bus_wdata),
      .latch_o (latch_q),
      .dir_o   (dir_q)
   );

   gpio_port_sync #(
      .WIDTH  (WIDTH),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pad_in),
      .sync_o  (pin_sync)
   );

   gpio_port_pad #(
      .WIDTH     (WIDTH),
      .LATCH_RST (LATCH_RST)
   ) u_pad (
      .clk     (clk),
      .rst_n   (rst_n),
      .latch_i (latch_q),
      .dir_i   (dir_q),
      .oe_o    (pad_oe),
      .do_o    (pad_do),
      .pu_o    (pad_pu)
   );

   gpio_port_rdmux #(
      .WIDTH     (WIDTH),
      .READ_FLOP (READ_FLOP)
   ) u_rdmux (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_i   (sel),
      .latch_i (latch_q),
      .dir_i   (dir_q),
      .pin_i   (pin_sync),
      .rdata_o (bus_rdata)
   );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          READ_FLOP   = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [WIDTH-1:0]  bus_wdata,
   input logic [WIDTH-1:0]  bus_rdata,
   input logic [WIDTH-1:0]  pad_in,
   input logic [WIDTH-1:0]  pad_oe,
   input logic [WIDTH-1:0]  pad_do,
   input logic [WIDTH-1:0]  pad_pu,
   input logic [WIDTH-1:0]  latch_q,
   input logic [WIDTH-1:0]  dir_q
);

   // Cycles since reset, saturating, so that the two-cycle look-back stays inside them
   logic [1:0] up_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              up_cnt <= 2'd0;
      else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
   end

   a_r1_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(0)) |=> latch_q == $past(bus_wdata));

   a_r2_drive: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pad_oe == $past(dir_q)) && (pad_do == ($past(dir_q) & $past(latch_q))));

   a_r3_pullup: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> pad_pu == (~$past(dir_q) & $past(latch_q)));

   a_r4_dir_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(1)) |=> $stable(latch_q));

   a_r5_reset_vals: assert property (@(posedge clk)
      !rst_n |=> (latch_q == '1) && (dir_q == '0));

   a_r6_read_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (!READ_FLOP && bus_addr == ADDR_W'(0)) |-> bus_rdata == latch_q);

   a_r7_sync_depth: assert property (@(posedge clk) disable iff (!rst_n)
      (!READ_FLOP && SYNC_STAGES == 2 && up_cnt >= 2'd2 && bus_addr == ADDR_W'(2))
         |-> bus_rdata == $past(pad_in, 2));

   a_r9_hole_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(3)) |=> $stable(latch_q) && $stable(dir_q));

endmodule

bind gpio_port gpio_port_chk #(
   .WIDTH       (WIDTH),
   .ADDR_W      (ADDR_W),
   .SYNC_STAGES (SYNC_STAGES),
   .READ_FLOP   (READ_FLOP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_in    (pad_in),
   .pad_oe    (pad_oe),
   .pad_do    (pad_do),
   .pad_pu    (pad_pu),
   .latch_q   (latch_q),
   .dir_q     (dir_q)
);

// File: tb/gpio_port_bench.sv
module gpio_port_bench;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_wr = 1'b0;
   logic [1:0]   bus_addr = 2'd0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic [W-1:0] pad_in = '0;
   logic [W-1:0] pad_oe, pad_do, pad_pu;

   int  total = 0;
   int  bad   = 0;
   bit  done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_port u_gpio_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pad_in    (pad_in),
      .pad_oe    (pad_oe),
      .pad_do    (pad_do),
      .pad_pu    (pad_pu)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // Write is sampled at the next rising edge; returns at the negedge after it
   task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [W-1:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   // Pads follow one edge after the register
   task automatic pads_settle();
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [W-1:0] d;
      bus_read(2'd0, d); chk("R5 latch after reset", d, 8'hFF);
      bus_read(2'd1, d); chk("R5 dir after reset", d, 8'h00);
      chk("R5 pad_oe after reset", pad_oe, 8'h00);
      chk("R5 pad_do after reset", pad_do, 8'h00);
      chk("R5 pad_pu after reset", pad_pu, 8'hFF);
   endtask

   task automatic t_latch_rw();
      logic [W-1:0] d;
      bus_write(2'd0, 8'hA5);
      bus_read(2'd0, d); chk("R1 readback A5", d, 8'hA5);
      chk("R8 pads not yet updated", pad_pu, 8'hFF);
      pads_settle();
      chk("R8 pullups follow one edge later", pad_pu, 8'hA5);
      bus_write(2'd0, 8'h3C);
      bus_read(2'd0, d); chk("R1 readback 3C", d, 8'h3C);
   endtask

   task automatic t_drive();
      bus_write(2'd1, 8'hFF);
      bus_write(2'd0, 8'h5A);
      pads_settle();
      chk("R2 pad_oe all outputs", pad_oe, 8'hFF);
      chk("R2 pad_do drives latch", pad_do, 8'h5A);
      chk("R2 no pullups on outputs", pad_pu, 8'h00);
   endtask

   task automatic t_pullup();
      bus_write(2'd1, 8'h00);
      bus_write(2'd0, 8'h96);
      pads_settle();
      chk("R3 pad_oe all inputs", pad_oe, 8'h00);
      chk("R3 pad_do quiet on inputs", pad_do, 8'h00);
      chk("R3 pullups from latch", pad_pu, 8'h96);
   endtask

   task automatic t_dir_keeps_latch();
      logic [W-1:0] d;
      bus_write(2'd0, 8'hC3);
      bus_write(2'd1, 8'h0F);
      bus_read(2'd0, d); chk("R4 latch after dir 0F", d, 8'hC3);
      bus_write(2'd1, 8'hF0);
      bus_read(2'd0, d); chk("R4 latch after dir F0", d, 8'hC3);
      pads_settle();
      chk("R10 mixed pad_oe", pad_oe, 8'hF0);
      chk("R10 mixed pad_do", pad_do, 8'hC0);
      chk("R10 mixed pad_pu", pad_pu, 8'h03);
      bus_write(2'd1, 8'h00);
      pads_settle();
      chk("R4 pullups restored after turnaround", pad_pu, 8'hC3);
   endtask

   task automatic t_read_latch_not_pin();
      logic [W-1:0] d;
      bus_write(2'd0, 8'h81);
      @(negedge clk); pad_in = 8'h7E;
      repeat (3) @(negedge clk);
      bus_read(2'd0, d); chk("R6 input mode reads latch", d, 8'h81);
      bus_write(2'd1, 8'hFF);
      bus_read(2'd0, d); chk("R6 output mode reads latch", d, 8'h81);
      bus_write(2'd1, 8'h00);
   endtask

   task automatic t_sync();
      logic [W-1:0] d;
      @(negedge clk);
      pad_in = 8'h55; bus_addr = 2'd2;
      @(negedge clk); #1; d = bus_rdata;
      chk("R7 not visible after one edge", d, 8'h7E);
      @(negedge clk); #1; d = bus_rdata;
      chk("R7 visible after two edges", d, 8'h55);
      pad_in = 8'hAA;
      @(negedge clk); #1; d = bus_rdata;
      chk("R7 second change, one edge", d, 8'h55);
      @(negedge clk); #1; d = bus_rdata;
      chk("R7 second change, two edges", d, 8'hAA);
   endtask

   task automatic t_hole();
      logic [W-1:0] d;
      bus_write(2'd0, 8'h69);
      bus_write(2'd1, 8'h0C);
      pads_settle();
      bus_write(2'd3, 8'h00);
      pads_settle();
      bus_read(2'd0, d); chk("R9 latch untouched", d, 8'h69);
      bus_read(2'd1, d); chk("R9 dir untouched", d, 8'h0C);
      chk("R9 pad_oe untouched", pad_oe, 8'h0C);
      chk("R9 pad_do untouched", pad_do, 8'h08);
      chk("R9 pad_pu untouched", pad_pu, 8'h61);
      bus_read(2'd3, d); chk("R9 hole reads zero", d, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latch_rw();
      t_drive();
      t_pullup();
      t_dir_keeps_latch();
      t_read_latch_not_pin();
      t_sync();
      t_hole();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule